// File: doc/BRIEF.md
# Up/Down Interval Timer with Single-Shot Stop

This block is a programmable interval timer. A prescaler divides the block clock, and each prescaler tick moves a counter one step up or down. When the counter passes its reload boundary it raises an update event. The update event sets a sticky flag and can pulse a DMA request line. The flag can also drive an interrupt line. Each of these two outputs has its own enable bit.

Software writes the block through a simple write port. That port sets the control bits (run, direction, single-shot), the two output enables, the prescaler divisor and the reload value. It also clears the flag. Prescaler and reload values written while the counter runs are held in staging registers. They move into the working copies at the next update event, so the current period always completes with the values it started with. In single-shot mode the block clears its own run bit at the first update event. This gives a single timed period.

Top module: `updown_timer`

## Requirements
- R1: After reset the count is 0, the run, direction and single-shot bits are 0, both output enables are 0, the flag is 0, and the irq and DMA outputs are low.
- R2: While running with a prescaler value P, the counter moves one step every P+1 clock cycles. The first step lands on the (P+1)th rising edge after the edge that sets the run bit. Registers are selected by write address: 0 control, 1 enables, 2 status, 3 prescaler, 4 reload.
- R3: Control bit 1 at 0 selects up counting. A tick at a count equal to the reload value A returns the count to 0 and raises the update event. Otherwise the tick adds one.
- R4: Control bit 1 at 1 selects down counting. A tick at count 0 loads A and raises the update event. Otherwise the tick subtracts one.
- R5: Control bit 0 is the run bit. While it reads 0, the count holds its value.
- R6: With control bit 2 (single-shot) set, the run bit clears on the clock edge that carries the update event. The count then stays at its wrapped value.
- R7: Status bit 0 is a flag. It is set by every update event and stays set. Writing status with bit 0 at 0 clears it. Writing status with bit 0 at 1 leaves it unchanged. An update event in the same cycle as a clear wins.
- R8: The irq output follows the flag AND enables bit 0.
- R9: When enables bit 1 is set, the DMA request goes high for exactly one cycle, starting at the edge that carries an update event. With that bit at 0 the request stays low.
- R10: Prescaler and reload writes made while the counter runs take effect only after the next update event. Writes made while it is stopped take effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | DATA_W | Write data |
| cnt_o | output | CNT_W | Current count |
| run_o | output | 1 | Run bit as held by the block |
| flag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Gated interrupt line |
| dma_req_o | output | 1 | One-cycle DMA request pulse |

## Verification
A register write takes effect on the rising edge that captures it, and the result is visible at the next falling edge. The bench therefore drives every write at a falling edge and samples exactly one falling edge later. With prescaler P, the count after k edges of running is floor(k/(P+1)) modulo the period. The flag, the DMA pulse and a single-shot stop all appear on that same wrap edge. Every vector waits an exact number of falling edges after the run-bit write, so the check lands on the cycle in which each result is due. The DMA test samples the edge before the pulse, the pulse edge and the edge after it, to prove the pulse lasts one cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [2:0] {
      ADR_CTRL = 3'd0,
      ADR_IEN  = 3'd1,
      ADR_STAT = 3'd2,
      ADR_PSC  = 3'd3,
      ADR_ARR  = 3'd4
   } tmr_addr_e;

   localparam int CTL_RUN = 0;
   localparam int CTL_DIR = 1;
   localparam int CTL_SSH = 2;
   localparam int IEN_IRQ = 0;
   localparam int IEN_DMA = 1;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              upd,
   output logic              run,
   output logic              dir,
   output logic              ssh,
   output logic              ie_irq,
   output logic              ie_dma,
   output logic              flag,
   output logic [PSC_W-1:0]  psc_pre,
   output logic [CNT_W-1:0]  arr_pre
);
   logic wr_ctrl, wr_ien, wr_stat, wr_psc, wr_arr;

   always_comb begin
      wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
      wr_ien  = wr_en && (wr_addr == ADR_IEN);
      wr_stat = wr_en && (wr_addr == ADR_STAT);
      wr_psc  = wr_en && (wr_addr == ADR_PSC);
      wr_arr  = wr_en && (wr_addr == ADR_ARR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         dir     <= 1'b0;
         ssh     <= 1'b0;
         ie_irq  <= 1'b0;
         ie_dma  <= 1'b0;
         flag    <= 1'b0;
         psc_pre <= '0;
         arr_pre <= '1;
      end else begin
         if (wr_ctrl) begin
            run <= wr_data[CTL_RUN];
            dir <= wr_data[CTL_DIR];
            ssh <= wr_data[CTL_SSH];
         end else if (upd && ssh) begin
            run <= 1'b0;
         end
         if (wr_ien) begin
            ie_irq <= wr_data[IEN_IRQ];
            ie_dma <= wr_data[IEN_DMA];
         end
         if (upd)
            flag <= 1'b1;
         else if (wr_stat && !wr_data[0])
            flag <= 1'b0;
         if (wr_psc) psc_pre <= wr_data[PSC_W-1:0];
         if (wr_arr) arr_pre <= wr_data[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] div_m1,
   output logic             tick
);
   logic [PSC_W-1:0] acc;

   assign tick = run && (acc == div_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc <= '0;
      else if (!run)    acc <= '0;
      else if (tick)    acc <= '0;
      else              acc <= acc + 1'b1;
   end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             dir,
   input  logic [CNT_W-1:0] arr_pre,
   input  logic [PSC_W-1:0] psc_pre,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] arr_act,
   output logic [PSC_W-1:0] psc_act,
   output logic             upd
);
   logic at_edge, load;

   always_comb begin
      at_edge = dir ? (cnt == '0) : (cnt == arr_act);
      upd     = tick && at_edge;
      load    = upd || !run;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         arr_act <= '1;
         psc_act <= '0;
      end else begin
         if (load) begin
            arr_act <= arr_pre;
            psc_act <= psc_pre;
         end
         if (tick) begin
            if (at_edge) cnt <= dir ? arr_act : '0;
            else         cnt <= dir ? cnt - 1'b1 : cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/updown_timer.sv
module updown_timer
   import tmr_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 16,
   parameter int PSC_W   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              run_o,
   output logic              flag_o,
   output logic              irq_o,
   output logic              dma_req_o
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie in 2..DATA_W");
   end
   if (PSC_W < 1 || PSC_W > DATA_W) begin : g_bad_psc
      $error("PSC_W must lie in 1..DATA_W");
   end

   logic             run_w, dir_w, ssh_w, ie_irq_w, ie_dma_w, flag_w;
   logic             tick_w, upd_w;
   logic [PSC_W-1:0] psc_pre_w, psc_act_w;
   logic [CNT_W-1:0] arr_pre_w, arr_act_w, cnt_w;
   logic             dma_q;

   tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .upd(upd_w), .run(run_w), .dir(dir_w),
      .ssh(ssh_w), .ie_irq(ie_irq_w), .ie_dma(ie_dma_w), .flag(flag_w),
      .psc_pre(psc_pre_w), .arr_pre(arr_pre_w)
   );

   tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(run_w), .div_m1(psc_act_w), .tick(tick_w)
   );

   tmr_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_w), .tick(tick_w), .dir(dir_w),
      .arr_pre(arr_pre_w), .psc_pre(psc_pre_w), .cnt(cnt_w),
      .arr_act(arr_act_w), .psc_act(psc_act_w), .upd(upd_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dma_q <= 1'b0;
      else        dma_q <= upd_w && ie_dma_w;
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= flag_w && ie_irq_w;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = flag_w && ie_irq_w;
   end

   assign cnt_o     = cnt_w;
   assign run_o     = run_w;
   assign flag_o    = flag_w;
   assign dma_req_o = dma_q;
endmodule

// File: rtl/updown_timer_chk.sv
module updown_timer_chk #(
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [CNT_W-1:0]  cnt_o,
   input logic              run_o,
   input logic              flag_o,
   input logic              irq_o,
   input logic              dma_req_o,
   input logic              tick,
   input logic              upd,
   input logic              dir,
   input logic              ssh,
   input logic [CNT_W-1:0]  arr_act
);
   logic clr_wr, ctl_wr;
   assign clr_wr = wr_en && (wr_addr == 3'd2) && !wr_data[0];
   assign ctl_wr = wr_en && (wr_addr == 3'd0);

   // R3
   up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !dir && (cnt_o != arr_act) |=> cnt_o == $past(cnt_o) + 1'b1);

   // R4
   down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && dir && (cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);

   // R5
   hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_o |=> $stable(cnt_o));

   // R6
   single_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd && ssh && !ctl_wr |=> !run_o);

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o && !clr_wr |=> flag_o);

   // R9
   dma_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_req_o) |-> flag_o);

   if (!IRQ_REG) begin : g_irq_chk
      // R8
      irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !flag_o |-> !irq_o);
   end
endmodule

bind updown_timer updown_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .cnt_o(cnt_o), .run_o(run_o), .flag_o(flag_o), .irq_o(irq_o),
   .dma_req_o(dma_req_o), .tick(tick_w), .upd(upd_w), .dir(dir_w),
   .ssh(ssh_w), .arr_act(arr_act_w)
);

// File: tb/tb_updown_timer.sv
module tb_updown_timer;
   localparam int DW = 16;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [CW-1:0] cnt_o;
   logic          run_o, flag_o, irq_o, dma_req_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   updown_timer dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cnt_o(cnt_o), .run_o(run_o), .flag_o(flag_o),
      .irq_o(irq_o), .dma_req_o(dma_req_o)
   );

   typedef struct packed {
      logic [7:0]  psc;
      logic [7:0]  arr;
      logic        dir;
      logic        ssh;
      logic [7:0]  n;
      logic [15:0] cnt;
      logic        flag;
      logic        run;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{8'd0, 8'd9, 1'b0, 1'b0, 8'd5,  16'd5, 1'b0, 1'b1},
      '{8'd0, 8'd9, 1'b0, 1'b0, 8'd10, 16'd0, 1'b1, 1'b1},
      '{8'd0, 8'd9, 1'b0, 1'b0, 8'd13, 16'd3, 1'b1, 1'b1},
      '{8'd2, 8'd4, 1'b0, 1'b0, 8'd7,  16'd2, 1'b0, 1'b1},
      '{8'd1, 8'd3, 1'b0, 1'b0, 8'd8,  16'd0, 1'b1, 1'b1},
      '{8'd0, 8'd5, 1'b1, 1'b0, 8'd1,  16'd5, 1'b1, 1'b1},
      '{8'd0, 8'd5, 1'b1, 1'b0, 8'd4,  16'd2, 1'b1, 1'b1},
      '{8'd0, 8'd3, 1'b0, 1'b1, 8'd4,  16'd0, 1'b1, 1'b0},
      '{8'd0, 8'd3, 1'b0, 1'b1, 8'd9,  16'd0, 1'b1, 1'b0},
      '{8'd0, 8'd3, 1'b1, 1'b1, 8'd1,  16'd3, 1'b1, 1'b0},
      '{8'd0, 8'd0, 1'b0, 1'b0, 8'd3,  16'd0, 1'b1, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1 reset state
      check("R1 cnt", cnt_o, 0);
      check("R1 run", run_o, 0);
      check("R1 flag", flag_o, 0);
      check("R1 irq", irq_o, 0);
      check("R1 dma", dma_req_o, 0);

      // Vector table: R2 R3 R4 R6 R7
      for (int i = 0; i < NV; i++) begin
         do_reset();
         wr(3'd3, 16'(VEC[i].psc));
         wr(3'd4, 16'(VEC[i].arr));
         wr(3'd0, {13'd0, VEC[i].ssh, VEC[i].dir, 1'b1});
         wait_n(int'(VEC[i].n));
         check($sformatf("R2/R3/R4 vec%0d cnt", i), cnt_o, 32'(VEC[i].cnt));
         check($sformatf("R7 vec%0d flag", i), flag_o, 32'(VEC[i].flag));
         check($sformatf("R6 vec%0d run", i), run_o, 32'(VEC[i].run));
      end

      // R8 irq gating and R7 clear semantics (flag set from last vector)
      wr(3'd0, 16'd0);
      check("R8 irq masked", irq_o, 0);
      wr(3'd1, 16'd1);
      check("R8 irq enabled", irq_o, 1);
      wr(3'd2, 16'd1);
      check("R7 write one keeps flag", flag_o, 1);
      wr(3'd2, 16'd0);
      check("R7 write zero clears", flag_o, 0);
      check("R8 irq follows flag", irq_o, 0);

      // R5 hold while stopped
      do_reset();
      wr(3'd4, 16'd20);
      wr(3'd0, 16'd1);
      wait_n(4);
      wr(3'd0, 16'd0);
      wait_n(6);
      check("R5 held count", cnt_o, 5);

      // R9 dma pulse
      do_reset();
      wr(3'd1, 16'd2);
      wr(3'd4, 16'd3);
      wr(3'd0, 16'd1);
      wait_n(3);
      check("R9 dma before wrap", dma_req_o, 0);
      wait_n(1);
      check("R9 dma at wrap", dma_req_o, 1);
      check("R9 cnt at wrap", cnt_o, 0);
      wait_n(1);
      check("R9 dma one cycle", dma_req_o, 0);

      // R9 dma disabled
      do_reset();
      wr(3'd4, 16'd1);
      wr(3'd0, 16'd1);
      wait_n(2);
      check("R9 flag set", flag_o, 1);
      check("R9 dma gated off", dma_req_o, 0);

      // R10 reload staged until update
      do_reset();
      wr(3'd4, 16'd3);
      wr(3'd0, 16'd1);
      wait_n(1);
      wr(3'd4, 16'd7);
      check("R10 cnt after write", cnt_o, 2);
      wait_n(2);
      check("R10 old reload wrap", cnt_o, 0);
      wait_n(7);
      check("R10 new reload used", cnt_o, 7);
      wait_n(1);
      check("R10 new wrap", cnt_o, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule